// File: doc/BRIEF.md
# Pipelined No-Wait Burst SRAM

This block is a synthesizable model of a single-clock synchronous static RAM whose data bus never idles when the traffic turns between reads and writes. Every command input is captured on the rising clock edge. The bus time slot for a command is the interval that begins one edge after the command edge and ends at the next edge. A read drives the bus during its slot. A write takes its data from the bus during its slot. Because both directions use the same slot, any sequence of reads and writes can be issued on consecutive clocks.

A command either starts a new access or continues the current one. Starting a command loads an external address and decodes three chip selects. Continuing a command steps a 2-bit burst counter, and the counter forms the low address bits in either linear or interleaved order. Per-byte write enables mask writes. A hold input freezes the whole pipeline. A small parameterised array stands in for the storage core. The bus has no back-pressure: the data slot follows the command at a fixed distance, so the block has no valid/ready handshake. The hold input is the only way to pause transfers.

Top module: `nws_sram`

## Requirements
- R1: A read command captured at rising edge k drives the stored word on `data` from edge k+1 until edge k+2. `data` is high-impedance in every slot that does not carry read data.
- R2: For a write command captured at edge k, the word on `data` is captured at edge k+2. Only lanes whose `lane_wr_n` bit was 0 at edge k are stored. Lane i is bits 8i+7..8i, and the lanes with bit 1 keep their old contents.
- R3: Reads and writes to any addresses can be issued on consecutive edges in any mix, with no idle cycles between them.
- R4: A start command (`burst_next`=0) is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect, which neither writes nor drives the bus.
- R5: With `burst_next`=1, the command type of the current access is repeated at the next burst address. `write_n` is ignored. A continuation after a deselect stays deselected.
- R6: With `ilv_order`=0, beat n of a burst has low address bits (start + n) mod 4. The upper bits are unchanged, so the fifth beat returns to the start word.
- R7: With `ilv_order`=1, beat n has low address bits start XOR n.
- R8: While `hold`=1 at an edge, every input is ignored and all pipeline state, including the burst counter and the bus driver, keeps its value.
- R9: A read issued on the edge right after a write to the same address returns the newly written lanes, merged with the old lanes that were not written.
- R10: After reset, no command is pending and `data` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | 1 freezes the whole pipeline |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 starts a command, 1 continues the burst |
| write_n | input | 1 | 0 makes a start command a write |
| lane_wr_n | input | NB | Per-lane write enables, active low |
| ilv_order | input | 1 | 1 interleaved, 0 linear burst order |
| addr | input | AW | Word address for a start command |
| data | inout | NB*BYTE | Shared data bus |

## Verification
Single writes followed by reads, including a write to one lane only, show whether lane masking keeps the untouched byte. Alternating write/read sequences on the same and on different addresses separate correct slot alignment from a forwarding fault in the back-to-back case. Bursts that start at word 1 in both orders separate linear from interleaved stepping, because the two orders produce different beat sequences. A five-beat burst confirms the wrap. Each chip-select combination is exercised separately, as are continuations after a deselect. Holds placed in the middle of a read slot and in the middle of a burst show whether the bus data and the counter stay frozen or slip.

// File: rtl/nws_pkg.sv
package nws_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_order_e;

  // low two address bits for a given beat of a burst
  function automatic logic [1:0] burst_lsb(logic [1:0] start, logic [1:0] step,
                                           burst_order_e ord);
    return (ord == ORD_INTERLEAVE) ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/nws_lane.sv
module nws_lane #(
  parameter int BYTE = 8
) (
  input  logic [BYTE-1:0] keep,
  input  logic [BYTE-1:0] take,
  input  logic            pick,
  output logic [BYTE-1:0] y
);
  assign y = pick ? take : keep;
endmodule

// File: rtl/nws_ctrl.sv
module nws_ctrl
  import nws_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          sel_ok,
  input  logic          burst_next,
  input  logic          write_n,
  input  logic          ilv_order,
  input  logic [NB-1:0] lane_wr_n,
  input  logic [AW-1:0] addr,
  output logic          s1_valid,
  output logic          s1_wr,
  output logic [AW-1:0] s1_addr,
  output logic [NB-1:0] s1_lanes,
  output logic [1:0]    beat
);
  logic [AW-1:0] base_q, n_base, n_addr;
  logic [1:0]    n_beat;
  logic          n_valid, n_wr;

  always_comb begin
    if (burst_next) begin
      n_valid = s1_valid;
      n_wr    = s1_wr;
      n_base  = base_q;
      n_beat  = beat + 2'd1;
    end else begin
      n_valid = sel_ok;
      n_wr    = !write_n;
      n_base  = addr;
      n_beat  = 2'd0;
    end
    n_addr = {n_base[AW-1:2], burst_lsb(n_base[1:0], n_beat, burst_order_e'(ilv_order))};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_lanes <= '0;
      base_q   <= '0;
      beat     <= 2'd0;
    end else if (!hold) begin
      s1_valid <= n_valid;
      s1_wr    <= n_wr;
      s1_addr  <= n_addr;
      s1_lanes <= ~lane_wr_n;
      base_q   <= n_base;
      beat     <= n_beat;
    end
  end
endmodule

// File: rtl/nws_core.sv
module nws_core #(
  parameter int AW   = 6,
  parameter int NB   = 2,
  parameter int BYTE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic                 s1_valid,
  input  logic                 s1_wr,
  input  logic [AW-1:0]        s1_addr,
  input  logic [NB-1:0]        s1_lanes,
  input  logic [NB*BYTE-1:0]   din,
  output logic                 s2_valid,
  output logic                 s2_wr,
  output logic                 rd_oe,
  output logic [NB*BYTE-1:0]   rd_q
);
  localparam int DW    = NB * BYTE;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_lanes;
  logic [DW-1:0] wr_old, rd_old, wr_word, rd_word;
  logic          wr_now, fwd;

  assign wr_now = s2_valid && s2_wr;
  assign fwd    = wr_now && (s2_addr == s1_addr);
  assign wr_old = mem[s2_addr];
  assign rd_old = mem[s1_addr];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    nws_lane #(.BYTE(BYTE)) u_wr (
      .keep(wr_old[g*BYTE +: BYTE]), .take(din[g*BYTE +: BYTE]),
      .pick(s2_lanes[g]), .y(wr_word[g*BYTE +: BYTE]));
    nws_lane #(.BYTE(BYTE)) u_rd (
      .keep(rd_old[g*BYTE +: BYTE]), .take(din[g*BYTE +: BYTE]),
      .pick(fwd && s2_lanes[g]), .y(rd_word[g*BYTE +: BYTE]));
  end

  always_ff @(posedge clk) begin
    if (!hold && wr_now) mem[s2_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
      rd_oe    <= 1'b0;
      rd_q     <= '0;
    end else if (!hold) begin
      s2_valid <= s1_valid;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
      rd_oe    <= s1_valid && !s1_wr;
      if (s1_valid && !s1_wr) rd_q <= rd_word;
    end
  end
endmodule

// File: rtl/nws_sram.sv
module nws_sram #(
  parameter int AW   = 6,
  parameter int NB   = 2,
  parameter int BYTE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_next,
  input  logic              write_n,
  input  logic [NB-1:0]     lane_wr_n,
  input  logic              ilv_order,
  input  logic [AW-1:0]     addr,
  inout  wire  [NB*BYTE-1:0] data
);
  localparam int DW = NB * BYTE;

  logic          sel_ok, s1_valid, s1_wr, s2_valid, s2_wr, rd_oe;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_lanes;
  logic [1:0]    beat;
  logic [DW-1:0] rd_q, din;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
  assign din    = data;
  assign data   = rd_oe ? rd_q : {DW{1'bz}};

  nws_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel_ok(sel_ok),
    .burst_next(burst_next), .write_n(write_n), .ilv_order(ilv_order),
    .lane_wr_n(lane_wr_n), .addr(addr), .s1_valid(s1_valid), .s1_wr(s1_wr),
    .s1_addr(s1_addr), .s1_lanes(s1_lanes), .beat(beat));

  nws_core #(.AW(AW), .NB(NB), .BYTE(BYTE)) u_core (
    .clk(clk), .rst_n(rst_n), .hold(hold), .s1_valid(s1_valid), .s1_wr(s1_wr),
    .s1_addr(s1_addr), .s1_lanes(s1_lanes), .din(din), .s2_valid(s2_valid),
    .s2_wr(s2_wr), .rd_oe(rd_oe), .rd_q(rd_q));
endmodule

// File: rtl/nws_sram_chk.sv
module nws_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold,
  input logic       burst_next,
  input logic       sel_a_n,
  input logic       sel_b,
  input logic       sel_c_n,
  input logic       s1_valid,
  input logic       s1_wr,
  input logic       s2_valid,
  input logic       s2_wr,
  input logic       rd_oe,
  input logic [1:0] beat
);
  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rd_oe);
  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && s1_valid && !s1_wr) |=> rd_oe);
  a_r2_write_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_wr) |-> !rd_oe);
  a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !burst_next && !(!sel_a_n && sel_b && !sel_c_n)) |=> !s1_valid);
  a_r5_burst_keeps_type: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && burst_next) |=> (s1_valid == $past(s1_valid)) && (s1_wr == $past(s1_wr)));
  a_r6_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && burst_next) |=> beat == $past(beat) + 2'd1);
  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(rd_oe) && $stable(s1_valid) && $stable(beat) && $stable(s2_valid));
endmodule

bind nws_sram nws_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .burst_next(burst_next),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .s1_valid(s1_valid),
  .s1_wr(s1_wr), .s2_valid(s2_valid), .s2_wr(s2_wr), .rd_oe(rd_oe), .beat(beat));

// File: tb/nws_sram_test.sv
`timescale 1ns/1ps
module nws_sram_test;
  logic clk = 0, rst_n = 0, hold = 0;
  logic sel_a_n = 1, sel_b = 0, sel_c_n = 1, burst_next = 0, write_n = 1, ilv = 0;
  logic [1:0] lanes_n = 2'b11;
  logic [5:0] addr = '0;
  logic tb_en = 0;
  logic [15:0] tb_val = '0;
  wire [15:0] data_bus;
  assign data_bus = tb_en ? tb_val : 16'hzzzz;

  nws_sram #(.AW(6), .NB(2), .BYTE(8)) uut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .burst_next(burst_next), .write_n(write_n),
    .lane_wr_n(lanes_n), .ilv_order(ilv), .addr(addr), .data(data_bus));

  always #4 clk = ~clk;

  int ecnt = 0, nchk = 0, nerr = 0;
  bit done = 0;
  logic drv_en [256];
  logic [15:0] drv_val [256];
  logic chk_en [256];
  logic [15:0] chk_val [256];
  string chk_tag [256];
  logic [15:0] model [64];
  bit b_sel, b_wr;
  logic [5:0] b_base;
  logic [1:0] b_cnt;

  function automatic logic [15:0] mrg(logic [15:0] o, logic [15:0] n, logic [1:0] ln);
    logic [15:0] r = o;
    for (int k = 0; k < 2; k++) if (!ln[k]) r[k*8 +: 8] = n[k*8 +: 8];
    return r;
  endfunction

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sched_drv(int e, logic [15:0] v);
    drv_en[e % 256] = 1; drv_val[e % 256] = v;
  endtask
  task automatic sched_chk(int e, logic [15:0] v, string tag);
    chk_en[e % 256] = 1; chk_val[e % 256] = v; chk_tag[e % 256] = tag;
  endtask

  task automatic tick();
    int i;
    @(posedge clk);
    ecnt++;
    i = ecnt % 256;
    #1;
    tb_en = drv_en[i]; tb_val = drv_val[i]; drv_en[i] = 0;
    @(negedge clk);
    if (chk_en[i]) begin check(data_bus, chk_val[i], chk_tag[i]); chk_en[i] = 0; end
  endtask

  task automatic set_idle();
    hold = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1; burst_next = 0; write_n = 1; lanes_n = 2'b11;
  endtask
  task automatic raw();
    set_idle(); tick();
  endtask

  // beat handling for a selected access at effective address ea
  task automatic beat_io(bit wr, logic [5:0] ea, logic [1:0] ln, logic [15:0] d, string tag);
    if (wr) begin sched_drv(ecnt + 1, d); model[ea] = mrg(model[ea], d, ln); end
    else sched_chk(ecnt + 1, model[ea], tag);
  endtask
  task automatic probe(bit wr, string tag);
    if (wr) sched_drv(ecnt + 1, 16'hffff);
    else begin sched_drv(ecnt + 1, 16'h0000); sched_chk(ecnt + 1, 16'h0000, tag); end
  endtask

  task automatic op(bit wr, logic [5:0] a, logic [1:0] ln, logic [15:0] d, string tag);
    hold = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0; burst_next = 0;
    write_n = !wr; addr = a; lanes_n = ln;
    tick();
    b_sel = 1; b_wr = wr; b_base = a; b_cnt = 0;
    beat_io(wr, a, ln, d, tag);
  endtask
  task automatic cont(logic [1:0] ln, logic [15:0] d, string tag);
    logic [5:0] ea;
    hold = 0; burst_next = 1; write_n = 0; lanes_n = ln;
    tick();
    b_cnt = b_cnt + 2'd1;
    ea = {b_base[5:2], ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
    if (b_sel) beat_io(b_wr, ea, ln, d, tag); else probe(b_wr, tag);
  endtask
  task automatic desel(logic sa, logic sb, logic sc, bit wr, logic [5:0] a, string tag);
    hold = 0; sel_a_n = sa; sel_b = sb; sel_c_n = sc; burst_next = 0;
    write_n = !wr; addr = a; lanes_n = 2'b00;
    tick();
    b_sel = 0; b_wr = wr;
    probe(wr, tag);
  endtask
  task automatic idle(string tag);
    desel(1, 0, 1, 0, 6'h00, tag);
  endtask
  task automatic flush();
    idle("R1 idle slot"); idle("R1 idle slot");
  endtask

  task automatic t_reset();
    repeat (3) tick();
    sched_drv(ecnt + 1, 0); sched_chk(ecnt + 1, 0, "R10 bus quiet after reset");
    sched_drv(ecnt + 2, 0); sched_chk(ecnt + 2, 0, "R10 bus quiet after reset");
    rst_n = 1;
    raw(); raw();
  endtask

  task automatic t_single();
    op(1, 6'h05, 2'b00, 16'h1234, "R2");
    flush();
    op(0, 6'h05, 2'b11, 0, "R1 read after write");
    flush();
    op(1, 6'h05, 2'b01, 16'hab99, "R2");   // lane 1 only
    flush();
    op(0, 6'h05, 2'b11, 0, "R2 lane mask keeps lane 0");
    flush();
  endtask

  task automatic t_b2b();
    op(1, 6'h08, 2'b00, 16'h0f0f, "R3");
    op(0, 6'h08, 2'b11, 0, "R9 forwarded full word");
    op(1, 6'h09, 2'b00, 16'h7777, "R3");
    op(1, 6'h08, 2'b10, 16'h55c3, "R3");   // lane 0 only
    op(0, 6'h08, 2'b11, 0, "R9 merged lanes");
    op(0, 6'h09, 2'b11, 0, "R3 read between writes");
    op(1, 6'h0a, 2'b00, 16'h2468, "R3");
    op(0, 6'h09, 2'b11, 0, "R3 read after write other addr");
    flush();
    op(0, 6'h0a, 2'b11, 0, "R3 write landed");
    flush();
  endtask

  task automatic t_sel();
    desel(1, 1, 0, 1, 6'h05, "R4");
    desel(0, 0, 0, 1, 6'h05, "R4");
    desel(0, 1, 1, 1, 6'h05, "R4");
    desel(0, 0, 1, 0, 6'h05, "R4 deselected read no drive");
    flush();
    op(0, 6'h05, 2'b11, 0, "R4 deselected writes ignored");
    flush();
  endtask

  task automatic t_linear();
    ilv = 0;
    op(1, 6'h10, 2'b00, 16'h1000, "R6"); op(1, 6'h11, 2'b00, 16'h1111, "R6");
    op(1, 6'h12, 2'b00, 16'h1222, "R6"); op(1, 6'h13, 2'b00, 16'h1333, "R6");
    flush();
    op(0, 6'h11, 2'b11, 0, "R6 beat0");
    cont(2'b11, 0, "R6 beat1"); cont(2'b11, 0, "R6 beat2");
    cont(2'b11, 0, "R6 beat3"); cont(2'b11, 0, "R6 wrap beat4");
    flush();
  endtask

  task automatic t_interleave();
    ilv = 1;
    op(0, 6'h11, 2'b11, 0, "R7 beat0");
    cont(2'b11, 0, "R7 beat1"); cont(2'b11, 0, "R7 beat2"); cont(2'b11, 0, "R7 beat3");
    flush();
    op(1, 6'h22, 2'b00, 16'ha0a0, "R5");
    cont(2'b00, 16'ha1a1, "R5"); cont(2'b00, 16'ha2a2, "R5"); cont(2'b00, 16'ha3a3, "R5");
    flush();
    op(0, 6'h20, 2'b11, 0, "R5 burst write word0"); op(0, 6'h21, 2'b11, 0, "R5 burst write word1");
    op(0, 6'h22, 2'b11, 0, "R5 burst write word2"); op(0, 6'h23, 2'b11, 0, "R5 burst write word3");
    flush();
    ilv = 0;
  endtask

  task automatic t_desel_cont();
    desel(0, 0, 0, 0, 6'h12, "R5 deselected start");
    cont(2'b11, 0, "R5 continuation stays deselected");
    cont(2'b11, 0, "R5 continuation stays deselected");
    desel(1, 1, 0, 1, 6'h12, "R5");
    cont(2'b00, 0, "R5"); cont(2'b00, 0, "R5");
    flush();
    op(0, 6'h12, 2'b11, 0, "R5 no write after deselect");
    op(0, 6'h13, 2'b11, 0, "R5 no write after deselect");
    flush();
  endtask

  task automatic t_hold_out();
    op(1, 6'h30, 2'b00, 16'h5a3c, "R8");
    raw(); raw();
    op(0, 6'h30, 2'b11, 0, "R8 read slot");
    raw();
    sched_chk(ecnt + 1, 16'h5a3c, "R8 data held on bus");
    sched_chk(ecnt + 2, 16'h5a3c, "R8 data held on bus");
    hold = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0; burst_next = 0;
    write_n = 0; addr = 6'h30; lanes_n = 2'b00;
    tick(); tick();
    sched_drv(ecnt + 1, 0); sched_chk(ecnt + 1, 0, "R8 bus released after hold");
    raw(); raw(); raw();
    op(0, 6'h30, 2'b11, 0, "R8 write during hold ignored");
    flush();
  endtask

  task automatic t_hold_burst();
    ilv = 0;
    op(0, 6'h11, 2'b11, 0, "R8 burst beat0");
    burst_next = 1; tick();
    sched_chk(ecnt + 1, model[6'h11], "R8 held beat0");
    sched_chk(ecnt + 2, model[6'h11], "R8 held beat0");
    hold = 1; tick(); tick();
    hold = 0;
    sched_chk(ecnt + 1, model[6'h12], "R8 beat1 after hold");
    tick();
    sched_chk(ecnt + 1, model[6'h13], "R8 counter held beat2");
    raw();
    flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) begin drv_en[k] = 0; chk_en[k] = 0; end
    t_reset();
    t_single();
    t_b2b();
    t_sel();
    t_linear();
    t_interleave();
    t_desel_cont();
    t_hold_out();
    t_hold_burst();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule